// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Add Overflow Trap

This block is the integer execute stage of a 32-bit load/store pipeline. Each cycle it may accept one operation: an operation code, two register operands and a 16-bit immediate field. The result is computed combinationally and captured in a result register on the next rising clock edge. Alongside the result, the register stage reports one of three outcomes: a write-back is due, a signed add overflowed, or the operation code was not recognised.

The operations are:
- signed and wrapping (unsigned) addition;
- bitwise AND and OR;
- loading an immediate into the upper half of the word;
- set-on-compare for equal, greater-or-equal, greater and less-or-equal, each in signed and unsigned form.

Every operation except the upper-immediate load has a register form and an immediate form. Which operations zero-extend the immediate and which sign-extend it is part of each operation's definition.

A signed add that overflows raises the trap flag instead of a write-back. In that case the result register keeps its previous contents, so no destination is updated.

Top module: `alu_exec_unit`

## Requirements
- R1: Synchronous active-high `rst` clears `res_q`, `res_valid`, `ovf_trap` and `illegal_op` to zero at the next rising edge, whatever the other inputs are.
- R2: ADD (op 0) and ADDI (op 1) produce the 32-bit sum of `src_a` and either `src_b` or the immediate sign-extended from bit 15.
- R3: ADD and ADDI overflow only when both addends have equal sign bits and the sum's sign bit differs from `src_a`'s. On overflow, `ovf_trap` is 1, `res_valid` is 0 and `res_q` keeps its previous value.
- R4: ADDU (op 2) and ADDUI (op 3) wrap modulo 2^32 and never raise `ovf_trap`. ADDUI zero-extends the immediate.
- R5: AND (op 4), ANDI (op 5), OR (op 6) and ORI (op 7) apply the bitwise operation to `src_a` and either `src_b` or the immediate zero-extended to 32 bits.
- R6: LHI (op 8) writes the immediate into bits 31:16 and zeros into bits 15:0, ignoring both register operands.
- R7: The register compares write exactly 1 when true and 0 otherwise: SEQ 9, SEQU 11, SGE 13, SGEU 15, SGT 17, SGTU 19, SLE 21, SLEU 23. The U forms compare unsigned and the others compare two's-complement.
- R8: The immediate compares use the immediate sign-extended from bit 15 as the second operand, with unsigned comparison for the U forms and a 0/1 result: SEQI 10, SEQUI 12, SGEI 14, SGEUI 16, SGTI 18, SGTUI 20, SLEI 22, SLEUI 24.
- R9: An op code of 25 to 31 sets `illegal_op` to 1 and `res_valid` to 0, and leaves `res_q` unchanged.
- R10: A cycle with `in_valid` low leaves `res_valid`, `ovf_trap` and `illegal_op` at 0 after the edge and `res_q` unchanged.
- R11: An accepted operation's outcome appears on the outputs after exactly one rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| res_q | output | 32 | Registered result |
| res_valid | output | 1 | Result is to be written back |
| ovf_trap | output | 1 | Signed add overflowed; write-back suppressed |
| illegal_op | output | 1 | Unrecognised operation code |

## Verification
The embedded assertions check the following on every cycle:
- at most one of write-back, trap and illegal is reported;
- the result register holds steady on a trap, an illegal code or an idle cycle;
- compare results are 0 or 1;
- LHI leaves the low half clear;
- the wrapping adds never trap;
- illegal codes are always flagged.

Only the bench's scenarios can show that the values themselves are right. That covers the sign-extension and zero-extension choice for each immediate form, signed against unsigned ordering at the 0x7FFFFFFF/0x80000000 boundary, the exact overflow condition, and the one-edge latency.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,  OP_ADDI  = 5'd1,  OP_ADDU  = 5'd2,  OP_ADDUI = 5'd3,
        OP_AND   = 5'd4,  OP_ANDI  = 5'd5,  OP_OR    = 5'd6,  OP_ORI   = 5'd7,
        OP_LHI   = 5'd8,
        OP_SEQ   = 5'd9,  OP_SEQI  = 5'd10, OP_SEQU  = 5'd11, OP_SEQUI = 5'd12,
        OP_SGE   = 5'd13, OP_SGEI  = 5'd14, OP_SGEU  = 5'd15, OP_SGEUI = 5'd16,
        OP_SGT   = 5'd17, OP_SGTI  = 5'd18, OP_SGTU  = 5'd19, OP_SGTUI = 5'd20,
        OP_SLE   = 5'd21, OP_SLEI  = 5'd22, OP_SLEU  = 5'd23, OP_SLEUI = 5'd24
    } op_e;

    localparam logic [OP_W-1:0] OP_LAST = 5'd24;
    localparam logic [OP_W-1:0] CMP_FIRST = 5'd9;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] imm_sx,
    output logic [DATA_W-1:0] imm_zx
);
    localparam int PAD_W = DATA_W - IMM_W;

    assign imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_zx = {{PAD_W{1'b0}}, imm};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    assign sum = a + b;
    // overflow: operands agree in sign, sum disagrees with first operand
    assign ovf = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              eq,
    output logic              s_gt,
    output logic              u_gt
);
    assign eq   = (a == b);
    assign s_gt = ($signed(a) > $signed(b));
    assign u_gt = (a > b);
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   res_q,
    output logic                res_valid,
    output logic                ovf_trap,
    output logic                illegal_op
);
    localparam int LO_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              valid;
        logic              ovf;
        logic              ill;
    } stage_t;

    stage_t st_d, st_q;

    logic [DATA_W-1:0] imm_sx, imm_zx, opnd_b, sum;
    logic              add_ovf, eq, s_gt, u_gt;

    alu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm(imm), .imm_sx(imm_sx), .imm_zx(imm_zx));

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .a(src_a), .b(opnd_b), .sum(sum), .ovf(add_ovf));

    alu_compare #(.DATA_W(DATA_W)) u_cmp (
        .a(src_a), .b(opnd_b), .eq(eq), .s_gt(s_gt), .u_gt(u_gt));

    // second operand selection: immediate extension depends on the operation
    always_comb begin
        case (op)
            OP_ADDI, OP_SEQI, OP_SEQUI, OP_SGEI, OP_SGEUI,
            OP_SGTI, OP_SGTUI, OP_SLEI, OP_SLEUI:  opnd_b = imm_sx;
            OP_ADDUI, OP_ANDI, OP_ORI:             opnd_b = imm_zx;
            default:                               opnd_b = src_b;
        endcase
    end

    function automatic logic [DATA_W-1:0] as_word(input logic flag);
        return {{(DATA_W-1){1'b0}}, flag};
    endfunction

    logic [DATA_W-1:0] val_d;
    logic              legal_d, trap_d;

    always_comb begin
        val_d   = '0;
        legal_d = 1'b1;
        trap_d  = 1'b0;
        case (op)
            OP_ADD, OP_ADDI:              begin val_d = sum; trap_d = add_ovf; end
            OP_ADDU, OP_ADDUI:            val_d = sum;
            OP_AND, OP_ANDI:              val_d = src_a & opnd_b;
            OP_OR, OP_ORI:                val_d = src_a | opnd_b;
            OP_LHI:                       val_d = {imm, {LO_W{1'b0}}};
            OP_SEQ, OP_SEQI,
            OP_SEQU, OP_SEQUI:            val_d = as_word(eq);
            OP_SGE, OP_SGEI:              val_d = as_word(s_gt | eq);
            OP_SGEU, OP_SGEUI:            val_d = as_word(u_gt | eq);
            OP_SGT, OP_SGTI:              val_d = as_word(s_gt);
            OP_SGTU, OP_SGTUI:            val_d = as_word(u_gt);
            OP_SLE, OP_SLEI:              val_d = as_word(~s_gt);
            OP_SLEU, OP_SLEUI:            val_d = as_word(~u_gt);
            default:                      legal_d = 1'b0;
        endcase

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ovf   = 1'b0;
        st_d.ill   = 1'b0;
        if (in_valid) begin
            if (!legal_d) begin
                st_d.ill = 1'b1;
            end else if (trap_d) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.res   = val_d;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_q      = st_q.res;
    assign res_valid  = st_q.valid;
    assign ovf_trap   = st_q.ovf;
    assign illegal_op = st_q.ill;

    // at most one outcome per cycle (R3, R9)
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({res_valid, ovf_trap, illegal_op}) <= 1);

    p_trap_holds_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> res_q == $past(res_q));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && (op == OP_ADDU || op == OP_ADDUI)) |-> !ovf_trap);

    p_lhi_low_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op) == OP_LHI) |-> res_q[LO_W-1:0] == '0);

    p_cmp_boolean_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op) >= CMP_FIRST && $past(op) <= OP_LAST)
            |-> res_q[DATA_W-1:1] == '0);

    p_illegal_flag_r9: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && op > OP_LAST) |-> illegal_op && !res_valid && res_q == $past(res_q));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !res_valid && !ovf_trap && !illegal_op && res_q == $past(res_q));
endmodule

// File: tb/alu_exec_unit_test.sv
module alu_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op;
    logic [31:0] src_a, src_b;
    logic [15:0] imm;
    logic [31:0] res_q;
    logic        res_valid, ovf_trap, illegal_op;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_exec_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .res_q(res_q), .res_valid(res_valid), .ovf_trap(ovf_trap), .illegal_op(illegal_op));

    // {op, a, b, imm, expected result, valid, ovf, ill, requirement}
    localparam int NV = 29;
    localparam logic [123:0] VEC [NV] = '{
        {5'd0,  32'h00000005, 32'h00000007, 16'h0000, 32'h0000000C, 3'b100, 4'd2}, // R2
        {5'd1,  32'h0000000A, 32'h0, 16'hFFFE, 32'h00000008, 3'b100, 4'd2},         // R2 negative imm
        {5'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h00000008, 3'b010, 4'd3},  // R3 trap, held
        {5'd1,  32'h80000000, 32'h0, 16'h8000, 32'h00000008, 3'b010, 4'd3},         // R3 trap, held
        {5'd0,  32'h80000000, 32'h7FFFFFFF, 16'h0000, 32'hFFFFFFFF, 3'b100, 4'd3},  // R3 mixed signs
        {5'd2,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 3'b100, 4'd4},  // R4 wrap
        {5'd3,  32'h7FFFFFFF, 32'h0, 16'hFFFF, 32'h8000FFFE, 3'b100, 4'd4},         // R4 zero-ext
        {5'd4,  32'hF0F0F0F0, 32'h0FF00FF0, 16'h0000, 32'h00F000F0, 3'b100, 4'd5},  // R5
        {5'd5,  32'hFFFFFFFF, 32'h0, 16'h8001, 32'h00008001, 3'b100, 4'd5},         // R5
        {5'd6,  32'h12340000, 32'h00005678, 16'h0000, 32'h12345678, 3'b100, 4'd5},  // R5
        {5'd7,  32'h00000000, 32'h0, 16'hF00F, 32'h0000F00F, 3'b100, 4'd5},         // R5
        {5'd8,  32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 32'hABCD0000, 3'b100, 4'd6},  // R6
        {5'd9,  32'h00000005, 32'h00000005, 16'h0000, 32'h00000001, 3'b100, 4'd7},  // R7
        {5'd13, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 3'b100, 4'd7},  // R7
        {5'd15, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000001, 3'b100, 4'd7},  // R7
        {5'd17, 32'h00000001, 32'hFFFFFFFF, 16'h0000, 32'h00000001, 3'b100, 4'd7},  // R7
        {5'd19, 32'h00000001, 32'hFFFFFFFF, 16'h0000, 32'h00000000, 3'b100, 4'd7},  // R7
        {5'd21, 32'h00000003, 32'h00000003, 16'h0000, 32'h00000001, 3'b100, 4'd7},  // R7
        {5'd23, 32'h80000000, 32'h7FFFFFFF, 16'h0000, 32'h00000000, 3'b100, 4'd7},  // R7
        {5'd10, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd14, 32'h00000000, 32'h0, 16'h8000, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd20, 32'h0000FFFF, 32'h0, 16'hFFFF, 32'h00000000, 3'b100, 4'd8},         // R8
        {5'd22, 32'hFFFF8000, 32'h0, 16'h8000, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd12, 32'h0000FFFF, 32'h0, 16'hFFFF, 32'h00000000, 3'b100, 4'd8},         // R8
        {5'd16, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd18, 32'h00000005, 32'h0, 16'h0004, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd24, 32'h00000005, 32'h0, 16'hFFFF, 32'h00000001, 3'b100, 4'd8},         // R8
        {5'd25, 32'h00000001, 32'h1, 16'h0001, 32'h00000001, 3'b001, 4'd9},         // R9
        {5'd31, 32'hFFFFFFFF, 32'h1, 16'hFFFF, 32'h00000001, 3'b001, 4'd9}          // R9
    };

    task automatic check(input string req, input logic [31:0] er, input logic [2:0] ef);
        checks++;
        if (res_q !== er || {res_valid, ovf_trap, illegal_op} !== ef) begin
            errors++;
            $display("FAIL %s: res=%h flags(v,o,i)=%b expected res=%h flags=%b",
                     req, res_q, {res_valid, ovf_trap, illegal_op}, er, ef);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] i);
        in_valid = v; op = o; src_a = a; src_b = b; imm = i;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b1, 5'd8, 32'h1, 32'h2, 16'h1234);
        @(negedge clk); @(negedge clk);
        check("R1", 32'h0, 3'b000);          // reset state
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(1'b1, VEC[k][123:119], VEC[k][118:87], VEC[k][86:55], VEC[k][54:39]);
            @(negedge clk);
            check($sformatf("R%0d", VEC[k][3:0]), VEC[k][38:7], VEC[k][6:4]);
        end

        // R10: idle cycle holds the result and clears the flags
        drive(1'b0, 5'd0, 32'h3, 32'h4, 16'h0);
        @(negedge clk);
        check("R10", 32'h00000001, 3'b000);

        // R11: nothing changes before the edge, result after it
        drive(1'b1, 5'd0, 32'h00000010, 32'h00000020, 16'h0);
        #1;
        check("R11", 32'h00000001, 3'b000);
        @(negedge clk);
        check("R11", 32'h00000030, 3'b100);

        // R3 then recovery: trap holds 0x30, next add writes
        drive(1'b1, 5'd1, 32'h7FFFFFFF, 32'h0, 16'h0001);
        @(negedge clk);
        check("R3", 32'h00000030, 3'b010);
        drive(1'b1, 5'd1, 32'h7FFFFFFE, 32'h0, 16'h0001);
        @(negedge clk);
        check("R2", 32'h7FFFFFFF, 3'b100);

        // R1: reset during an accepted operation wins
        rst = 1'b1;
        drive(1'b1, 5'd6, 32'hFFFF0000, 32'h0000FFFF, 16'h0);
        @(negedge clk);
        check("R1", 32'h0, 3'b000);
        rst = 1'b0;
        drive(1'b0, 5'd0, 32'h0, 32'h0, 16'h0);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule